// File: doc/BRIEF.md
# One-Wire Search ROM Accelerator

This block speeds up the one-wire ROM search by carrying out, in hardware, the three-slot sequence needed for every ROM bit. After the host has sent the search command byte over the bus, it raises the accelerator enable and then works through the 64-bit ROM one nibble at a time. Each byte it writes holds four preferred-path bits, one for each of the four ROM bit positions in the nibble. For each of those positions the block runs two read slots and one write slot. The read slots sample the true value and then the complement. The write slot sends the chosen direction, which deselects every device that disagrees with it.

When all four positions are done, the block returns one byte. That byte holds a discrepancy flag and the chosen ROM bit for each position. A full pass takes sixteen exchanges, starting with the least significant nibble. The bit-slot waveform generator is not part of this block. The block reaches it through a request/response pair: `slot_req` together with `slot_write` asks for a slot, and `slot_done` together with `slot_rbit` reports that the slot has finished.

Top module: `owsrch_accel`

## Requirements
- R1: While `srch_en` is low, `slot_req` stays low and a pulse on `tx_valid` starts nothing.
- R2: A byte on `tx_valid` is taken only when `srch_en` is high and no exchange is running. Bytes offered while an exchange is running are dropped and do not change the preferences in use.
- R3: Every ROM bit uses exactly three slots in this order: read, read, write. `slot_write` is 0 for a read and 1 for a write. `slot_req` and `slot_write` stay constant until the cycle in which `slot_done` is high.
- R4: The four bits of an exchange are handled in the order nibble bit 0 to nibble bit 3. The preferred bit for nibble bit k is taken from transmitted byte bit 2k+1. The even bit positions of the transmitted byte are ignored.
- R5: If the two reads for a bit differ, the block writes the value of the first read, clears the discrepancy flag and reports the first read as the chosen bit.
- R6: If both reads are 0, the block writes the preferred bit, sets the discrepancy flag and reports the preferred bit as the chosen bit.
- R7: If both reads are 1 (no device present), the block writes 1 and sets both the flag and the chosen bit. On an empty bus the last exchange therefore returns bits 7 and 6 set, which marks the pass as a bus error.
- R8: In the returned byte, the flag for nibble bit k sits at bit 2k and the chosen bit at bit 2k+1. `rx_byte` is loaded and `rx_full` rises in the cycle after the twelfth `slot_done` of the exchange. `rx_byte` stays unchanged while `rx_full` is high.
- R9: `rx_full` is cleared by `rx_ack` and also by the acceptance of a new byte.
- R10: If `srch_en` goes low during an exchange, the exchange is abandoned. `slot_req` drops in the same cycle, `rx_full` is not raised and `rx_byte` keeps its old value.
- R11: After reset, `rx_full`, `rx_byte` and `slot_req` are all 0.
- R12: Successive exchanges continue the same bus pass without any re-initialisation. Sixteen exchanges therefore return the complete 64-bit ROM of one device that is present on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srch_en | input | 1 | Accelerator enable; clearing it abandons the current exchange |
| tx_valid | input | 1 | Host writes a path byte |
| tx_byte | input | 8 | Preferred-path bits at odd positions |
| rx_ack | input | 1 | Host has read the result; clears `rx_full` |
| rx_byte | output | 8 | Interleaved flags (even bits) and chosen bits (odd bits) |
| rx_full | output | 1 | Result byte is ready |
| slot_req | output | 1 | A bit slot is requested |
| slot_write | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit | output | 1 | Value to send in a write slot |
| slot_done | input | 1 | The requested slot has finished |
| slot_rbit | input | 1 | Bus value sampled in a read slot |

## Verification
The assertions check on every cycle the properties that do not depend on the bus contents:
- the read, read, write ordering of slots;
- that a request stays stable until it completes;
- that slots are requested only while the block is enabled;
- that a result arrives after exactly twelve slots;
- that the written direction follows the two captured reads whenever those reads differ or are both 1.

The case where both reads are 0 and the preference wins can only be shown by the bench's scenarios. The same is true of the bit positions used in the transmitted and returned bytes, of the complete ROM recovered after sixteen exchanges with several devices and with opposite preferences, and of the bus-error pattern on an empty bus.

// File: rtl/owsrch_accel.sv
module owsrch_accel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srch_en,
  input  logic       tx_valid,
  input  logic [7:0] tx_byte,
  input  logic       rx_ack,
  output logic [7:0] rx_byte,
  output logic       rx_full,
  output logic       slot_req,
  output logic       slot_write,
  output logic       slot_wbit,
  input  logic       slot_done,
  input  logic       slot_rbit
);
  localparam int NBITS = 4;

  typedef enum logic [1:0] {S_IDLE, S_RD_TRUE, S_RD_COMP, S_WRITE} st_t;

  st_t        st;
  logic [1:0] bidx;
  logic [NBITS-1:0] pref, flg, chs, flg_n, chs_n;
  logic       rd_t, rd_c;
  logic [2*NBITS-1:0] packed_res;

  wire idle     = (st == S_IDLE);
  wire accept   = srch_en && tx_valid && idle;
  wire cur_pref = pref[bidx];
  wire differ   = rd_t ^ rd_c;

  assign slot_req   = srch_en && !idle;
  assign slot_write = (st == S_WRITE);
  assign slot_wbit  = differ ? rd_t : (rd_t | cur_pref);

  wire slot_end = slot_req && slot_done;
  wire bit_end  = slot_end && slot_write;
  wire byte_end = bit_end && (bidx == 2'(NBITS-1));

  always_comb begin
    flg_n = flg;
    chs_n = chs;
    flg_n[bidx] = ~differ;
    chs_n[bidx] = slot_wbit;
    packed_res = '0;
    for (int k = 0; k < NBITS; k++) begin
      packed_res[2*k]   = flg_n[k];
      packed_res[2*k+1] = chs_n[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bidx <= '0;
      pref <= '0;
      flg <= '0;
      chs <= '0;
      rd_t <= 1'b0;
      rd_c <= 1'b0;
    end else if (!srch_en) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (tx_valid) begin
          for (int k = 0; k < NBITS; k++) pref[k] <= tx_byte[2*k+1];
          bidx <= '0;
          flg <= '0;
          chs <= '0;
          st <= S_RD_TRUE;
        end
        S_RD_TRUE: if (slot_done) begin
          rd_t <= slot_rbit;
          st <= S_RD_COMP;
        end
        S_RD_COMP: if (slot_done) begin
          rd_c <= slot_rbit;
          st <= S_WRITE;
        end
        S_WRITE: if (slot_done) begin
          flg <= flg_n;
          chs <= chs_n;
          bidx <= bidx + 2'd1;
          st <= (bidx == 2'(NBITS-1)) ? S_IDLE : S_RD_TRUE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_byte <= '0;
    end else if (byte_end) begin
      rx_full <= 1'b1;
      rx_byte <= packed_res;
    end else if (accept || rx_ack) begin
      rx_full <= 1'b0;
    end
  end
endmodule

module owsrch_accel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       srch_en,
  input logic       accept,
  input logic       slot_req,
  input logic       slot_write,
  input logic       slot_wbit,
  input logic       slot_done,
  input logic       slot_rbit,
  input logic       rx_full,
  input logic [7:0] rx_byte
);
  logic [1:0] rd_cnt;
  logic [3:0] tot;
  logic       r1, r2;

  always_ff @(posedge clk) begin
    if (!rst_n || !srch_en || accept) begin
      rd_cnt <= '0;
      if (!rst_n || accept) tot <= '0;
      if (!rst_n) begin r1 <= 1'b0; r2 <= 1'b0; end
    end else if (slot_req && slot_done) begin
      tot <= tot + 4'd1;
      if (slot_write) rd_cnt <= '0;
      else begin
        rd_cnt <= rd_cnt + 2'd1;
        if (rd_cnt == 2'd0) r1 <= slot_rbit; else r2 <= slot_rbit;
      end
    end
  end

  a_r1_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |-> srch_en);
  a_r3_write_after_two_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_write) |-> (rd_cnt == 2'd2));
  a_r3_reads_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_write) |-> (rd_cnt < 2'd2));
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_done && srch_en) |=> (!srch_en || (slot_req && $stable(slot_write))));
  a_r5_follow_read: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_write && (r1 != r2)) |-> (slot_wbit == r1));
  a_r7_both_high: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_write && r1 && r2) |-> slot_wbit);
  a_r8_twelve_slots: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> (tot == 4'd12));
  a_r8_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> (!rx_full || $stable(rx_byte)));
  a_r10_abort_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_en |=> !$rose(rx_full));
endmodule

bind owsrch_accel owsrch_accel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .accept(accept),
  .slot_req(slot_req), .slot_write(slot_write), .slot_wbit(slot_wbit),
  .slot_done(slot_done), .slot_rbit(slot_rbit),
  .rx_full(rx_full), .rx_byte(rx_byte)
);

// File: tb/owsrch_accel_tb_top.sv
module owsrch_accel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srch_en = 1'b0, tx_valid = 1'b0, rx_ack = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic [7:0] rx_byte;
  logic rx_full, slot_req, slot_write, slot_wbit;
  logic slot_done = 1'b0, slot_rbit = 1'b0;

  always #5 clk = ~clk;

  owsrch_accel dut_i (
    .clk(clk), .rst_n(rst_n), .srch_en(srch_en), .tx_valid(tx_valid),
    .tx_byte(tx_byte), .rx_ack(rx_ack), .rx_byte(rx_byte), .rx_full(rx_full),
    .slot_req(slot_req), .slot_write(slot_write), .slot_wbit(slot_wbit),
    .slot_done(slot_done), .slot_rbit(slot_rbit)
  );

  int checks = 0, errors = 0;
  logic [63:0] dev [3];
  int ndev = 3;
  logic [2:0] bus_act, mdl_act;
  int bus_bit = 0, rphase = 0, wk = 0, sidx = 0;
  logic bus_a = 1'b1;
  int mnib = 0, mslots = 0;
  logic mbusy = 1'b0, exp_full = 1'b0, started = 1'b0;
  logic [7:0] exp_byte = 8'h00, pend_byte = 8'h00;
  logic [3:0] exp_w = 4'h0;
  logic [3:0] exp_case [4];
  int req_cnt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: decides the expected result on acceptance, tracks completion.
  always @(posedge clk) begin
    if (!rst_n) begin
      mbusy = 1'b0; exp_full = 1'b0; exp_byte = 8'h00; mslots = 0;
    end else begin
      if (rx_ack) exp_full = 1'b0;
      if (!srch_en) mbusy = 1'b0;
      else if (mbusy && slot_done) begin
        mslots++;
        if (mslots == 12) begin exp_full = 1'b1; exp_byte = pend_byte; mbusy = 1'b0; end
      end else if (!mbusy && tx_valid) begin
        pend_byte = 8'h00;
        for (int k = 0; k < 4; k++) begin
          logic a, b, p, w, f;
          int idx;
          idx = mnib * 4 + k;
          a = 1'b1; b = 1'b1; p = tx_byte[2*k+1];
          for (int d = 0; d < ndev; d++)
            if (mdl_act[d]) begin if (dev[d][idx]) b = 1'b0; else a = 1'b0; end
          if (a != b) begin w = a; f = 1'b0; exp_case[k] = 4'd5; end
          else if (!a) begin w = p; f = 1'b1; exp_case[k] = 4'd6; end
          else begin w = 1'b1; f = 1'b1; exp_case[k] = 4'd7; end
          for (int d = 0; d < ndev; d++) if (dev[d][idx] != w) mdl_act[d] = 1'b0;
          exp_w[k] = w;
          pend_byte[2*k] = f;
          pend_byte[2*k+1] = w;
        end
        mnib = (mnib + 1) % 16;
        mbusy = 1'b1; mslots = 0; exp_full = 1'b0;
      end
    end
  end

  // Continuous comparison of the result interface against the model
  always @(negedge clk) begin
    if (started) begin
      if (slot_req) req_cnt++;
      chk(rx_full == exp_full, "R8 rx_full", 64'(rx_full), 64'(exp_full));
      if (exp_full) chk(rx_byte == exp_byte, "R8 rx_byte", 64'(rx_byte), 64'(exp_byte));
    end
  end

  // Bit-slot responder emulating a wired-AND bus
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (slot_done) begin
        slot_done = 1'b0; cnt = 0;
      end else if (slot_req) begin
        cnt++;
        if (cnt >= 1 + (sidx % 3)) begin
          sidx++;
          if (!slot_write) begin
            logic a, b;
            a = 1'b1; b = 1'b1;
            for (int d = 0; d < ndev; d++)
              if (bus_act[d]) begin if (dev[d][bus_bit]) b = 1'b0; else a = 1'b0; end
            chk(rphase < 2, "R3 read count", 64'(rphase), 64'd1);
            slot_rbit = (rphase == 0) ? a : b;
            rphase++;
          end else begin
            chk(rphase == 2, "R3 reads before write", 64'(rphase), 64'd2);
            case (exp_case[wk])
              4'd5: chk(slot_wbit == exp_w[wk], "R5 write value", 64'(slot_wbit), 64'(exp_w[wk]));
              4'd6: chk(slot_wbit == exp_w[wk], "R6 write value", 64'(slot_wbit), 64'(exp_w[wk]));
              default: chk(slot_wbit == exp_w[wk], "R7 write value", 64'(slot_wbit), 64'(exp_w[wk]));
            endcase
            for (int d = 0; d < ndev; d++) if (dev[d][bus_bit] != slot_wbit) bus_act[d] = 1'b0;
            bus_bit = (bus_bit + 1) % 64;
            wk = (wk + 1) % 4;
            rphase = 0;
          end
          slot_done = 1'b1;
        end
      end else cnt = 0;
    end
  end

  task automatic bus_reset(input int n);
    ndev = n;
    bus_act = 3'b111; mdl_act = 3'b111;
    bus_bit = 0; mnib = 0; rphase = 0; wk = 0;
  endtask

  task automatic xchg(input logic [7:0] b, input bit do_ack, input bit poke, output logic [7:0] r);
    @(negedge clk); tx_valid = 1'b1; tx_byte = b;
    @(negedge clk); tx_valid = 1'b0;
    if (poke) begin
      @(negedge clk); tx_valid = 1'b1; tx_byte = ~b;
      @(negedge clk); tx_valid = 1'b0;
    end
    while (!rx_full) @(negedge clk);
    r = rx_byte;
    if (do_ack) begin
      rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
    end
  endtask

  task automatic run_pass(input logic [7:0] b, input bit alt_ack, output logic [63:0] rom, output logic [7:0] last);
    logic [7:0] r;
    rom = '0;
    for (int i = 0; i < 16; i++) begin
      xchg(b, !(alt_ack && (i % 2 == 1)), (i == 2), r);
      for (int k = 0; k < 4; k++) rom[4*i+k] = r[2*k+1];
      last = r;
    end
    if (!rx_full) ;
    else begin rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rom1, rom2;
    logic [7:0] last, saved;
    int rc;
    dev[0] = 64'h1111_2222_3333_4440;
    dev[1] = 64'h1111_2222_3333_4441;
    dev[2] = 64'h5111_2222_3333_4442;
    bus_act = 3'b111; mdl_act = 3'b111;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_full == 1'b0, "R11 rx_full", 64'(rx_full), 0);
    chk(rx_byte == 8'h00, "R11 rx_byte", 64'(rx_byte), 0);
    chk(slot_req == 1'b0, "R11 slot_req", 64'(slot_req), 0);
    started = 1'b1;

    // R1: disabled block ignores writes
    rc = req_cnt;
    tx_valid = 1'b1; tx_byte = 8'hAA;
    @(negedge clk); tx_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(req_cnt == rc, "R1 no slot while disabled", 64'(req_cnt), 64'(rc));
    chk(rx_full == 1'b0, "R1 no result while disabled", 64'(rx_full), 0);

    // R4/R6/R12: preference 0 at odd bits, junk at even bits
    srch_en = 1'b1;
    bus_reset(3);
    run_pass(8'h55 & 8'h55 & 8'h55 ^ 8'h55 | 8'h55 & 8'h55, 1'b0, rom1, last);
    chk(rom1 == dev[0], "R12 pass with preference 0", rom1, dev[0]);

    // R6/R9/R2: preference 1, alternate exchanges cleared by the next byte
    bus_reset(3);
    run_pass(8'hAA, 1'b1, rom2, last);
    chk(rom2 == dev[1], "R12 pass with preference 1", rom2, dev[1]);
    chk(rom1 != rom2, "R4 preference steers path", rom2, ~rom1);

    // R7: empty bus returns bus-error marker
    bus_reset(0);
    run_pass(8'h00, 1'b0, rom1, last);
    chk(last == 8'hFF, "R7 empty bus last byte", 64'(last), 64'hFF);
    chk(rom1 == 64'hFFFF_FFFF_FFFF_FFFF, "R7 empty bus rom", rom1, 64'hFFFF_FFFF_FFFF_FFFF);

    // R10: abandoning an exchange
    bus_reset(3);
    saved = rx_byte;
    @(negedge clk); tx_valid = 1'b1; tx_byte = 8'h00;
    @(negedge clk); tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    srch_en = 1'b0;
    @(negedge clk);
    chk(slot_req == 1'b0, "R10 request drops", 64'(slot_req), 0);
    repeat (30) @(negedge clk);
    chk(rx_full == 1'b0, "R10 no result after abort", 64'(rx_full), 0);
    chk(rx_byte == saved, "R10 result kept", 64'(rx_byte), 64'(saved));

    // R12: a fresh pass after abort still works
    srch_en = 1'b1;
    bus_reset(3);
    run_pass(8'h00, 1'b0, rom1, last);
    chk(rom1 == dev[0], "R12 pass after abort", rom1, dev[0]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule